// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Front End

This block sits at the command entry of a serial flash slave. It watches chip select, the serial clock and the DQ0 input line. Over each frame it assembles an 8-bit opcode and keeps the write-enable latch, a single bit that every modifying command depends on. The latch must be set before any program, erase or register-write command is allowed to start. Commands that switch the address mode to four bytes or back also need it. A modifying command that arrives with the latch set is reported by a one-cycle accept pulse, and the latch stays set while that operation runs. When the operation reports completion on a done input, the latch clears.

The serial lines are assumed to be synchronous to the block clock and slow against it. Each level of the serial clock is held for at least two block clock cycles. The block clock therefore samples the serial clock and finds its edges. A status-read command returns the latch state on DQ1. This gives the surrounding logic, and a bench, a way to see the latch and the in-progress flag through the normal serial interface.

Top module: `sflash_wel_front`

## Requirements
- R1: After reset, `wel`, `accept`, `cmd_valid` and `dq1_oe` are all 0.
- R2: While `cs_n` is low, the block takes one opcode bit from `dq0` on each rising edge of `sck`, most significant bit first. After the 8th bit, `cmd_valid` pulses for exactly one cycle. `cmd_op` then holds the opcode and `cmd_kind` holds its class: 0 = other, 1 = set-latch (0x06), 2 = clear-latch (0x04), 3 = status read (0x05), 4 = modify.
- R3: Opcode 0x06 sets `wel` only when `cs_n` rises after exactly 8 clock bits in the frame.
- R4: Opcode 0x04 clears `wel` under the same exact-8-bit framing rule.
- R5: The modify opcodes are 0x02, 0xA2, 0xD2, 0x32, 0x38, 0x42, 0xE5, 0x20, 0xD8, 0xC7, 0x01, 0xB1, 0x81, 0x61, 0xC5, 0xB7 and 0xE9. When one of them completes its 8th bit while `wel` is 1 and no operation is in progress, `accept` pulses for one cycle and an operation is in progress from then on.
- R6: A modify opcode that arrives while `wel` is 0 is ignored. No `accept` pulse occurs and `wel` stays 0.
- R7: An `op_done` pulse while an operation is in progress clears `wel` and ends the operation. An `op_done` pulse with no operation in progress has no effect.
- R8: While an operation is in progress, the set-latch, clear-latch and modify commands have no effect. `wel` stays 1 and no `accept` pulse occurs.
- R9: After a status-read opcode, `dq1_oe` rises at the falling `sck` edge that ends the 8th bit. From that edge `dq1` shifts out the byte {6'b0, wel, in-progress}, most significant bit first, advancing one bit per falling edge. `dq1_oe` drops once `cs_n` is high.
- R10: `dq1_oe` stays 0 for the whole of every frame whose opcode is not the status read, including every set-latch frame.
- R11: Frames that carry any bit count other than 8 leave `wel` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous and slow against `clk` |
| cs_n | input | 1 | Chip select, active low |
| dq0 | input | 1 | Serial command input |
| op_done | input | 1 | Pulse marking the end of an accepted modify operation |
| wel | output | 1 | Write-enable latch state |
| accept | output | 1 | One-cycle pulse: modify command accepted |
| cmd_valid | output | 1 | One-cycle pulse: opcode captured |
| cmd_op | output | 8 | Last captured opcode |
| cmd_kind | output | 3 | Class of `cmd_op` (encoding in R2) |
| dq1 | output | 1 | Serial status output |
| dq1_oe | output | 1 | Output enable for `dq1` |

## Verification
The in-progress state is the hardest situation to reach. It only exists between an accepted modify command and the next done pulse, and it shows at the ports only through the status byte. The stimulus reaches it in a fixed order:

1. Set the latch.
2. Send a program opcode.
3. While done is held off, send clear-latch, a second modify and a status read.
4. Read the status byte back on DQ1.

A full sweep of all 256 opcodes, run once with the latch set and once with it clear, covers the decode. A second sweep of frame lengths from 1 to 12 bits covers the exact-eight framing rule.

// File: rtl/sflash_wel_pkg.sv
// Package: shared opcode constants, command classes and the modify-opcode table.
// Assumes opcodes are a fixed 8 bits wide.
package sflash_wel_pkg;

    localparam int OP_BITS   = 8;
    localparam int KIND_W    = 3;
    localparam int N_MODIFY  = 17;

    localparam logic [OP_BITS-1:0] OPC_SET_LATCH = 8'h06;
    localparam logic [OP_BITS-1:0] OPC_CLR_LATCH = 8'h04;
    localparam logic [OP_BITS-1:0] OPC_STATUS    = 8'h05;

    typedef enum logic [KIND_W-1:0] {
        KIND_OTHER  = 3'd0,
        KIND_SET    = 3'd1,
        KIND_CLR    = 3'd2,
        KIND_STATUS = 3'd3,
        KIND_MODIFY = 3'd4
    } op_kind_e;

    // Every opcode gated by the write-enable latch.
    localparam logic [OP_BITS-1:0] MODIFY_OPS [N_MODIFY] = '{
        8'h02, 8'hA2, 8'hD2, 8'h32, 8'h38, 8'h42, 8'hE5, 8'h20, 8'hD8,
        8'hC7, 8'h01, 8'hB1, 8'h81, 8'h61, 8'hC5, 8'hB7, 8'hE9
    };

endpackage

// File: rtl/sflash_bit_rx.sv
// Bit receiver: detects serial clock edges and chip-select rise, shifts
// opcode bits MSB first and reports opcode completion and frame end.
// Assumes sck, cs_n and dq0 are synchronous to clk, and that each sck level
// lasts at least two clk cycles.
module sflash_bit_rx #(
    parameter int OP_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               dq0,
    output logic               sck_fall,
    output logic               op_stb,
    output logic [OP_BITS-1:0] op_byte,
    output logic               fr_end,
    output logic               fr_exact
);
    localparam int CNT_W = $clog2(OP_BITS) + 1;

    logic               sck_q;
    logic               cs_q;
    logic [CNT_W-1:0]   cnt;
    logic [OP_BITS-1:0] shreg;
    logic               sck_rise;
    logic               cs_rise;
    logic [OP_BITS-1:0] next_byte;

    // Edge and frame-boundary detection from the previous samples.
    always_comb begin
        sck_rise  = sck & ~sck_q & ~cs_n;
        sck_fall  = ~sck & sck_q & ~cs_n;
        cs_rise   = cs_n & ~cs_q;
        next_byte = {shreg[OP_BITS-2:0], dq0};
    end

    // Keep last-cycle copies of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Count the clocked bits of the current frame, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            cnt <= '0;
        end else if (sck_rise && cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Shift incoming bits in, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sck_rise) begin
            shreg <= next_byte;
        end
    end

    // Capture the opcode when its last bit arrives and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_stb  <= 1'b0;
            op_byte <= '0;
        end else begin
            op_stb <= sck_rise && (cnt == CNT_W'(OP_BITS - 1));
            if (sck_rise && (cnt == CNT_W'(OP_BITS - 1))) begin
                op_byte <= next_byte;
            end
        end
    end

    // Flag the frame end and whether it carried exactly one opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_end   <= 1'b0;
            fr_exact <= 1'b0;
        end else begin
            fr_end   <= cs_rise;
            fr_exact <= cs_rise && (cnt == CNT_W'(OP_BITS));
        end
    end

endmodule

// File: rtl/sflash_op_decode.sv
// Opcode classifier: maps an opcode to its command class. The modify set is
// matched against the package table, one comparator per table entry.
// Purely combinational.
module sflash_op_decode
    import sflash_wel_pkg::*;
(
    input  logic [OP_BITS-1:0] op_byte,
    output op_kind_e           kind
);
    logic [N_MODIFY-1:0] hit;

    // One comparator per gated opcode.
    for (genvar i = 0; i < N_MODIFY; i++) begin : g_match
        assign hit[i] = (op_byte == MODIFY_OPS[i]);
    end

    // Priority: the three fixed opcodes, then the modify table.
    always_comb begin
        if (op_byte == OPC_SET_LATCH)      kind = KIND_SET;
        else if (op_byte == OPC_CLR_LATCH) kind = KIND_CLR;
        else if (op_byte == OPC_STATUS)    kind = KIND_STATUS;
        else if (|hit)                     kind = KIND_MODIFY;
        else                               kind = KIND_OTHER;
    end

endmodule

// File: rtl/sflash_wel_latch.sv
// Latch controller: holds the write-enable latch and the in-progress flag,
// and issues the accept pulse. Assumes op_stb and fr_end never coincide.
// Set/clear act at frame end; modify acts at opcode completion.
module sflash_wel_latch
    import sflash_wel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_stb,
    input  op_kind_e kind,
    input  logic     fr_end,
    input  logic     fr_exact,
    input  logic     op_done,
    output logic     wel,
    output logic     busy,
    output logic     accept
);
    logic frame_ok;

    // A frame counts for set/clear only if it ended right after 8 bits.
    assign frame_ok = fr_end && fr_exact;

    // Latch, in-progress flag and accept pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel    <= 1'b0;
            busy   <= 1'b0;
            accept <= 1'b0;
        end else begin
            accept <= 1'b0;
            if (busy) begin
                if (op_done) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                end
            end else begin
                if (op_stb && kind == KIND_MODIFY && wel) begin
                    accept <= 1'b1;
                    busy   <= 1'b1;
                end
                if (frame_ok && kind == KIND_SET) begin
                    wel <= 1'b1;
                end else if (frame_ok && kind == KIND_CLR) begin
                    wel <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sflash_stat_tx.sv
// Status transmitter: after a status-read opcode, drives {zeros, wel, busy}
// on DQ1, MSB first, changing on falling serial clock edges. Keeps the
// output enable low at all other times.
module sflash_stat_tx
    import sflash_wel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sck_fall,
    input  logic     op_stb,
    input  op_kind_e kind,
    input  logic     wel,
    input  logic     busy,
    output logic     dq1,
    output logic     dq1_oe
);
    logic               armed;
    logic [OP_BITS-1:0] shreg;

    assign dq1 = shreg[OP_BITS-1];

    // Arm on the opcode, load on the next falling edge, then shift per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            dq1_oe <= 1'b0;
            shreg  <= '0;
        end else if (cs_n) begin
            armed  <= 1'b0;
            dq1_oe <= 1'b0;
        end else begin
            if (op_stb && kind == KIND_STATUS) begin
                armed <= 1'b1;
            end
            if (sck_fall) begin
                if (armed) begin
                    shreg  <= {{(OP_BITS-2){1'b0}}, wel, busy};
                    dq1_oe <= 1'b1;
                    armed  <= 1'b0;
                end else if (dq1_oe) begin
                    shreg <= {shreg[OP_BITS-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/sflash_wel_front.sv
// Top: serial flash command front end with the write-enable latch. Wires the
// bit receiver, opcode classifier, latch controller and status transmitter.
module sflash_wel_front
    import sflash_wel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               dq0,
    input  logic               op_done,
    output logic               wel,
    output logic               accept,
    output logic               cmd_valid,
    output logic [OP_BITS-1:0] cmd_op,
    output logic [KIND_W-1:0]  cmd_kind,
    output logic               dq1,
    output logic               dq1_oe
);
    logic     sck_fall;
    logic     op_stb;
    logic     fr_end;
    logic     fr_exact;
    logic     busy;
    op_kind_e kind;

    sflash_bit_rx #(.OP_BITS(OP_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .dq0      (dq0),
        .sck_fall (sck_fall),
        .op_stb   (op_stb),
        .op_byte  (cmd_op),
        .fr_end   (fr_end),
        .fr_exact (fr_exact)
    );

    sflash_op_decode u_dec (
        .op_byte (cmd_op),
        .kind    (kind)
    );

    sflash_wel_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_stb   (op_stb),
        .kind     (kind),
        .fr_end   (fr_end),
        .fr_exact (fr_exact),
        .op_done  (op_done),
        .wel      (wel),
        .busy     (busy),
        .accept   (accept)
    );

    sflash_stat_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck_fall (sck_fall),
        .op_stb   (op_stb),
        .kind     (kind),
        .wel      (wel),
        .busy     (busy),
        .dq1      (dq1),
        .dq1_oe   (dq1_oe)
    );

    assign cmd_valid = op_stb;
    assign cmd_kind  = kind;

endmodule

// File: rtl/sflash_wel_front_chk.sv
// Checker: temporal properties of the latch front end, bound to the top.
module sflash_wel_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_done,
    input logic       wel,
    input logic       busy,
    input logic       accept,
    input logic       cmd_valid,
    input logic [2:0] cmd_kind,
    input logic       fr_end,
    input logic       fr_exact,
    input logic       dq1_oe
);
    // R5
    accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (wel && busy));
    // R5
    accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    // R3
    wel_set_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(fr_end) && $past(fr_exact)));
    // R7
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_done && busy) |-> (!wel && !busy));
    // R8
    busy_holds_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> wel);
    // R10
    oe_status_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq1_oe) |-> (cmd_kind == 3'd3));
    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

bind sflash_wel_front sflash_wel_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_done   (op_done),
    .wel       (wel),
    .busy      (busy),
    .accept    (accept),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .fr_end    (fr_end),
    .fr_exact  (fr_exact),
    .dq1_oe    (dq1_oe)
);

// File: tb/sflash_wel_front_test.sv
// Bench: sweeps all opcodes with the latch set and clear, sweeps frame
// lengths, and walks the in-progress scenario through the status read.
module sflash_wel_front_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       dq0 = 1'b0;
    logic       op_done = 1'b0;
    logic       wel, accept, cmd_valid, dq1, dq1_oe;
    logic [7:0] cmd_op;
    logic [2:0] cmd_kind;

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int valid_cnt = 0;
    int oe_viol = 0;
    bit oe_window = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sflash_wel_front uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq0(dq0),
        .op_done(op_done), .wel(wel), .accept(accept), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_kind(cmd_kind), .dq1(dq1), .dq1_oe(dq1_oe)
    );

    // Pulse counters and output-enable monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (accept)    acc_cnt++;
            if (cmd_valid) valid_cnt++;
            if (oe_window && dq1_oe) oe_viol++;
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_mod(input logic [7:0] op);
        case (op)
            8'h02, 8'hA2, 8'hD2, 8'h32, 8'h38, 8'h42, 8'hE5, 8'h20, 8'hD8,
            8'hC7, 8'h01, 8'hB1, 8'h81, 8'h61, 8'hC5, 8'hB7, 8'hE9: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_kind(input logic [7:0] op);
        if (op == 8'h06) return 1;
        if (op == 8'h04) return 2;
        if (op == 8'h05) return 3;
        if (is_mod(op))  return 4;
        return 0;
    endfunction

    task automatic frame(input logic [7:0] op, input int nbits, input bit rd_en,
                         output logic [7:0] rd, output bit oe_ok);
        oe_window = (op != 8'h05);
        cs_n = 1'b0;
        ticks(2);
        for (int i = 0; i < nbits; i++) begin
            dq0 = (i < 8) ? op[7-i] : 1'b0;
            ticks(3);
            sck = 1'b1;
            ticks(3);
            sck = 1'b0;
        end
        rd = '0;
        oe_ok = 1'b1;
        if (rd_en) begin
            for (int k = 0; k < 8; k++) begin
                ticks(3);
                rd[7-k] = dq1;
                if (!dq1_oe) oe_ok = 1'b0;
                sck = 1'b1;
                ticks(3);
                sck = 1'b0;
            end
        end
        ticks(3);
        cs_n = 1'b1;
        ticks(4);
        oe_window = 1'b0;
    endtask

    task automatic send(input logic [7:0] op);
        logic [7:0] rd;
        bit ok;
        frame(op, 8, 1'b0, rd, ok);
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        ticks(1);
        op_done = 1'b0;
        ticks(2);
    endtask

    initial begin
        logic [7:0] rd;
        bit ok;
        int a0, v0, ew;
        ticks(4);
        rst_n = 1'b1;
        ticks(1);
        // R1 reset state
        chk(wel == 0, "R1 wel", wel, 0);
        chk(accept == 0, "R1 accept", accept, 0);
        chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
        chk(dq1_oe == 0, "R1 dq1_oe", dq1_oe, 0);

        // Opcode sweep with the latch clear and set (R2, R3, R4, R5, R6, R7).
        for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 256; op++) begin
                send(w ? 8'h06 : 8'h04);
                chk(wel == w[0], "R3/R4 prep", wel, w);
                a0 = acc_cnt;
                v0 = valid_cnt;
                send(op[7:0]);
                chk(valid_cnt == v0 + 1, "R2 cmd_valid count", valid_cnt - v0, 1);
                chk(cmd_op == op[7:0], "R2 cmd_op", cmd_op, op);
                chk(int'(cmd_kind) == exp_kind(op[7:0]), "R2 cmd_kind", cmd_kind, exp_kind(op[7:0]));
                chk(acc_cnt - a0 == int'(is_mod(op[7:0]) && w == 1), "R5/R6 accept",
                    acc_cnt - a0, int'(is_mod(op[7:0]) && w == 1));
                ew = (op == 8'h06) ? 1 : (op == 8'h04) ? 0 : w;
                chk(int'(wel) == ew, "R3/R4/R6 wel after frame", wel, ew);
                pulse_done();
                if (is_mod(op[7:0]) && w == 1) ew = 0;
                chk(int'(wel) == ew, "R7 wel after done", wel, ew);
            end
        end

        // Frame length sweep (R3, R4, R11).
        for (int n = 1; n <= 12; n++) begin
            send(8'h04);
            frame(8'h06, n, 1'b0, rd, ok);
            chk(int'(wel) == int'(n == 8), "R3/R11 set-latch length", wel, int'(n == 8));
            send(8'h06);
            frame(8'h04, n, 1'b0, rd, ok);
            chk(int'(wel) == int'(n != 8), "R4/R11 clear-latch length", wel, int'(n != 8));
        end

        // In-progress scenario (R8, R9, R7).
        send(8'h04);
        frame(8'h05, 8, 1'b1, rd, ok);
        chk(rd == 8'h00, "R9 status idle", rd, 0);
        chk(ok, "R9 dq1_oe during read", ok, 1);
        send(8'h06);
        frame(8'h05, 8, 1'b1, rd, ok);
        chk(rd == 8'h02, "R9 status latch set", rd, 2);
        a0 = acc_cnt;
        send(8'h02);
        chk(acc_cnt - a0 == 1, "R5 accept program", acc_cnt - a0, 1);
        send(8'h04);
        chk(wel == 1, "R8 clear ignored while busy", wel, 1);
        a0 = acc_cnt;
        send(8'hD8);
        chk(acc_cnt == a0, "R8 modify ignored while busy", acc_cnt - a0, 0);
        frame(8'h05, 8, 1'b1, rd, ok);
        chk(rd == 8'h03, "R9 status busy", rd, 3);
        chk(ok, "R9 dq1_oe busy read", ok, 1);
        pulse_done();
        chk(wel == 0, "R7 done clears", wel, 0);
        frame(8'h05, 8, 1'b1, rd, ok);
        chk(rd == 8'h00, "R7/R9 status after done", rd, 0);
        ticks(2);
        chk(dq1_oe == 0, "R9 oe off after cs high", dq1_oe, 0);

        // R10 no output enable outside status frames.
        chk(oe_viol == 0, "R10 dq1_oe in non-status frame", oe_viol, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule